// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block sits between a fetch stage that is shared by two execution pipelines and those two pipelines. In each clock cycle fetch offers up to two decoded instructions, oldest first. Each instruction carries a destination register, two source registers and an opaque tag. The block decides whether the two candidates may start together, one in each pipe, or whether only the older may start. Two candidates cannot start together when the younger reads a register the older writes. They also cannot start together when both write the same register. Register 0 never counts as a clash.

When only the older candidate starts, the younger one is not dropped and does not stall the front end. It is kept in a one-entry carry register and becomes the older member of the next pair, matched with the next instruction from fetch. While an instruction is being carried, the block tells fetch that it can take only one new instruction. A per-slot ready vector handles this. Fetch must then present its unconsumed younger instruction again as the older slot, so that no instruction is lost or repeated. The issue outputs are registered and appear one clock after the pair is taken. The older instruction always goes to pipe 0.

Top module: `dual_issue_pairer`

## Requirements
- R1: After a synchronous reset, both issue-valid bits are 0 and `fe_rdy` is `2'b11`.
- R2: When no carry is held and both fetch slots are valid and free of conflict, the instruction in slot 0 is issued on lane 0 and the instruction in slot 1 on lane 1. Both appear one clock after they are accepted.
- R3: If source 1 or source 2 of the younger candidate equals a nonzero destination of the older candidate, only the older one issues, on lane 0, and the younger one is carried.
- R4: If both candidates name the same nonzero destination, only the older one issues and the younger one is carried.
- R5: A register index of 0, in any field, never causes a conflict.
- R6: While an instruction is carried, `fe_rdy` is `2'b01`, and fetch slot 1 is ignored. The carried instruction issues on lane 0 in the next issue cycle, paired with fetch slot 0 under the same rules, so repeated conflicts chain.
- R7: An invalid slot is a bubble that never conflicts. If the older candidate is invalid, the younger one issues on lane 0. A carried instruction with an invalid slot 0 issues alone.
- R8: Lane 1 is valid only when lane 0 is valid, and the two issued instructions never conflict.
- R9: Reset discards a carried instruction. After reset it is never issued, and `fe_rdy` returns to `2'b11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fe_vld | input | 2 | Valid bit per fetch slot (bit 0 = older slot) |
| fe_tag | input | 2*TAG_W | Opaque tag per slot, slot i in bits [i*TAG_W +: TAG_W] |
| fe_rd | input | 2*REG_W | Destination register per slot |
| fe_rs1 | input | 2*REG_W | First source register per slot |
| fe_rs2 | input | 2*REG_W | Second source register per slot |
| fe_rdy | output | 2 | Slot i is consumed this cycle when bit i is 1 |
| is_vld | output | 2 | Issue valid per lane (bit 0 = pipe 0, older) |
| is_tag | output | 2*TAG_W | Issued tag per lane |
| is_rd | output | 2*REG_W | Issued destination register per lane |
| is_rs1 | output | 2*REG_W | Issued first source per lane |
| is_rs2 | output | 2*REG_W | Issued second source per lane |

## Verification
The issue lanes follow the pair accepted at a rising edge and are read 2 ns after that edge. `fe_rdy` depends only on the carry register, so it is checked at the falling edge in the same cycle, before new inputs are driven. The driver sets inputs at each falling edge and also queues the issue result that an in-order reference model predicts for them. The monitor takes exactly one queued item after each rising edge. This keeps every comparison in the cycle in which its result is due. The model walks the same stream of instructions and bubbles, and it tracks which slots fetch has actually given up.

// File: rtl/pair_pkg.sv
package pair_pkg;
    localparam int REG_W = 5;
    localparam int TAG_W = 8;
    localparam int LANES = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        reg_idx_t         rd;
        reg_idx_t         rs1;
        reg_idx_t         rs2;
    } ins_t;

    typedef struct packed {
        logic v;
        ins_t ins;
    } slot_t;

    localparam reg_idx_t ZERO_REG = '0;

    function automatic logic real_reg(reg_idx_t r);
        return r != ZERO_REG;
    endfunction

    // younger reads what older writes
    function automatic logic reads_dest(reg_idx_t s1, reg_idx_t s2, reg_idx_t wr);
        return real_reg(wr) && ((s1 == wr) || (s2 == wr));
    endfunction

    // both write the same register
    function automatic logic same_dest(reg_idx_t a, reg_idx_t b);
        return real_reg(a) && (a == b);
    endfunction
endpackage

// File: rtl/pair_select.sv
module pair_select
    import pair_pkg::*;
(
    input  slot_t               held,
    input  slot_t [LANES-1:0]   fetch,
    output slot_t               older,
    output slot_t               younger
);
    // A carried instruction is always older than anything newly fetched.
    always_comb begin
        if (held.v) begin
            older   = held;
            younger = fetch[0];
        end else begin
            older   = fetch[0];
            younger = fetch[1];
        end
    end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
    import pair_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     old_v,
    input  reg_idx_t old_rd,
    input  logic     yng_v,
    input  reg_idx_t yng_rd,
    input  reg_idx_t yng_rs1,
    input  reg_idx_t yng_rs2,
    output logic     raw,
    output logic     waw,
    output logic     conflict
);
    logic both_v;

    assign both_v   = old_v && yng_v;
    assign raw      = both_v && reads_dest(yng_rs1, yng_rs2, old_rd);
    assign waw      = both_v && same_dest(yng_rd, old_rd);
    assign conflict = raw || waw;

    // R5: an older instruction writing register 0 never blocks pairing
    p_zero_dest_free_r5: assert property (@(posedge clk) disable iff (rst)
        (old_rd == ZERO_REG) |-> !conflict);

    // R7: a bubble never raises a conflict
    p_bubble_free_r7: assert property (@(posedge clk) disable iff (rst)
        (!old_v || !yng_v) |-> !conflict);
endmodule

// File: rtl/pair_steer.sv
module pair_steer
    import pair_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  slot_t  older,
    input  slot_t  younger,
    input  logic   conflict,
    output slot_t  lane0,
    output slot_t  lane1,
    output slot_t  carry_n
);
    always_comb begin
        lane0   = '0;
        lane1   = '0;
        carry_n = '0;
        if (!older.v) begin
            lane0 = younger;             // compact a bubble out of lane 0
        end else if (younger.v && conflict) begin
            lane0   = older;
            carry_n = younger;           // younger waits for the next pair
        end else begin
            lane0 = older;
            lane1 = younger;
        end
    end

    // R8: lane 1 never issues without lane 0
    p_lane_order_r8: assert property (@(posedge clk) disable iff (rst)
        lane1.v |-> lane0.v);

    // R3: on a conflict the younger candidate is held, not dropped
    p_carry_on_clash_r3: assert property (@(posedge clk) disable iff (rst)
        (older.v && younger.v && conflict) |-> (carry_n.v && !lane1.v));
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
    import pair_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         fe_vld,
    input  logic [LANES*TAG_W-1:0]   fe_tag,
    input  logic [LANES*REG_W-1:0]   fe_rd,
    input  logic [LANES*REG_W-1:0]   fe_rs1,
    input  logic [LANES*REG_W-1:0]   fe_rs2,
    output logic [LANES-1:0]         fe_rdy,
    output logic [LANES-1:0]         is_vld,
    output logic [LANES*TAG_W-1:0]   is_tag,
    output logic [LANES*REG_W-1:0]   is_rd,
    output logic [LANES*REG_W-1:0]   is_rs1,
    output logic [LANES*REG_W-1:0]   is_rs2
);
    slot_t [LANES-1:0] fe_slot;
    slot_t [LANES-1:0] is_q;
    slot_t             carry_q;
    slot_t             carry_n;
    slot_t             older;
    slot_t             younger;
    slot_t             lane0;
    slot_t             lane1;
    logic              raw;
    logic              waw;
    logic              conflict;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fe_slot[g] = '{v: fe_vld[g],
                              ins: '{tag: fe_tag[g*TAG_W +: TAG_W],
                                     rd:  fe_rd[g*REG_W +: REG_W],
                                     rs1: fe_rs1[g*REG_W +: REG_W],
                                     rs2: fe_rs2[g*REG_W +: REG_W]}};
        assign is_vld[g]                = is_q[g].v;
        assign is_tag[g*TAG_W +: TAG_W] = is_q[g].ins.tag;
        assign is_rd[g*REG_W +: REG_W]  = is_q[g].ins.rd;
        assign is_rs1[g*REG_W +: REG_W] = is_q[g].ins.rs1;
        assign is_rs2[g*REG_W +: REG_W] = is_q[g].ins.rs2;
    end

    // While carrying, only slot 0 is taken; fetch re-offers slot 1 as slot 0.
    assign fe_rdy = {~carry_q.v, 1'b1};

    pair_select u_select (
        .held    (carry_q),
        .fetch   (fe_slot),
        .older   (older),
        .younger (younger)
    );

    pair_hazard u_hazard (
        .clk      (clk),
        .rst      (rst),
        .old_v    (older.v),
        .old_rd   (older.ins.rd),
        .yng_v    (younger.v),
        .yng_rd   (younger.ins.rd),
        .yng_rs1  (younger.ins.rs1),
        .yng_rs2  (younger.ins.rs2),
        .raw      (raw),
        .waw      (waw),
        .conflict (conflict)
    );

    pair_steer u_steer (
        .clk      (clk),
        .rst      (rst),
        .older    (older),
        .younger  (younger),
        .conflict (conflict),
        .lane0    (lane0),
        .lane1    (lane1),
        .carry_n  (carry_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= '0;
            is_q    <= '0;
        end else begin
            carry_q <= carry_n;
            is_q    <= {lane1, lane0};
        end
    end

    // R1 / R9: reset empties the lanes and drops any carried instruction
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (is_vld == '0 && fe_rdy == {LANES{1'b1}}));

    // R6: a carried instruction issues on lane 0 in the following cycle
    p_carry_issues_r6: assert property (@(posedge clk) disable iff (rst)
        carry_q.v |=> (is_q[0].v && is_q[0].ins == $past(carry_q.ins)));

    // R3 / R8: an issued pair never has a read-after-write clash
    p_pair_no_raw_r3: assert property (@(posedge clk) disable iff (rst)
        (is_q[0].v && is_q[1].v) |->
            !reads_dest(is_q[1].ins.rs1, is_q[1].ins.rs2, is_q[0].ins.rd));

    // R4: an issued pair never writes the same nonzero register twice
    p_pair_no_waw_r4: assert property (@(posedge clk) disable iff (rst)
        (is_q[0].v && is_q[1].v) |-> !same_dest(is_q[1].ins.rd, is_q[0].ins.rd));

    // R2: with no carry and a clean pair both lanes fill next cycle
    p_clean_pair_r2: assert property (@(posedge clk) disable iff (rst)
        (!carry_q.v && fe_vld == 2'b11 && !raw && !waw) |=> (is_vld == 2'b11));
endmodule

// File: tb/tb_dual_issue_pairer.sv
module tb_dual_issue_pairer;
    import pair_pkg::*;

    typedef struct {
        logic [1:0] v;
        ins_t       i0;
        ins_t       i1;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]         fe_vld = '0;
    logic [2*TAG_W-1:0] fe_tag = '0;
    logic [2*REG_W-1:0] fe_rd = '0, fe_rs1 = '0, fe_rs2 = '0;
    logic [1:0]         fe_rdy, is_vld;
    logic [2*TAG_W-1:0] is_tag;
    logic [2*REG_W-1:0] is_rd, is_rs1, is_rs2;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    after_rst = 1;
    slot_t m_carry = '0;
    exp_t  q[$];
    ins_t  pend[$];
    logic [TAG_W-1:0] next_tag = 8'd100;

    always #10 clk = ~clk;   // 50 MHz

    dual_issue_pairer dut (
        .clk(clk), .rst(rst), .fe_vld(fe_vld), .fe_tag(fe_tag), .fe_rd(fe_rd),
        .fe_rs1(fe_rs1), .fe_rs2(fe_rs2), .fe_rdy(fe_rdy), .is_vld(is_vld),
        .is_tag(is_tag), .is_rd(is_rd), .is_rs1(is_rs1), .is_rs2(is_rs2)
    );

    function automatic ins_t mk(int t, int d, int a, int b);
        ins_t r;
        r.tag = t[TAG_W-1:0]; r.rd = d[REG_W-1:0];
        r.rs1 = a[REG_W-1:0]; r.rs2 = b[REG_W-1:0];
        return r;
    endfunction

    function automatic slot_t sv(ins_t i);
        slot_t s; s.v = 1'b1; s.ins = i; return s;
    endfunction

    // reference pairing rules, written from the requirements
    function automatic bit m_raw(ins_t o, ins_t y);
        return (o.rd != 0) && (y.rs1 == o.rd || y.rs2 == o.rd);
    endfunction
    function automatic bit m_waw(ins_t o, ins_t y);
        return (o.rd != 0) && (y.rd == o.rd);
    endfunction

    task automatic check(string req, bit ok, string act, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic step(slot_t s0, slot_t s1, bit do_rst);
        exp_t  e;
        slot_t o, y;
        logic [1:0] er;
        @(negedge clk);
        er = m_carry.v ? 2'b01 : 2'b11;
        check(after_rst ? "R9" : (m_carry.v ? "R6" : "R2"), fe_rdy == er,
              $sformatf("rdy=%b", fe_rdy), $sformatf("rdy=%b", er));
        e.v = 2'b00; e.i0 = '0; e.i1 = '0;
        if (do_rst) begin
            e.req = "R9";
            m_carry = '0;
        end else begin
            if (m_carry.v) begin o = m_carry; y = s0; end
            else begin o = s0; y = s1; end
            if (!o.v) begin
                e.req = "R7";
                e.v = {1'b0, y.v}; e.i0 = y.ins; m_carry = '0;
            end else if (y.v && (m_raw(o.ins, y.ins) || m_waw(o.ins, y.ins))) begin
                e.req = m_raw(o.ins, y.ins) ? "R3" : "R4";
                e.v = 2'b01; e.i0 = o.ins; m_carry = y;
            end else begin
                if (!y.v) e.req = "R7";
                else if (o.ins.rd == 0 || y.ins.rs1 == 0 || y.ins.rs2 == 0) e.req = "R5";
                else if (m_carry.v) e.req = "R6";
                else e.req = "R2";
                e.v = {y.v, 1'b1}; e.i0 = o.ins; e.i1 = y.ins; m_carry = '0;
            end
        end
        q.push_back(e);
        after_rst = do_rst;
        rst    = do_rst;
        fe_vld = {s1.v, s0.v};
        fe_tag = {s1.ins.tag, s0.ins.tag};
        fe_rd  = {s1.ins.rd, s0.ins.rd};
        fe_rs1 = {s1.ins.rs1, s0.ins.rs1};
        fe_rs2 = {s1.ins.rs2, s0.ins.rs2};
    endtask

    // monitor: one expected item per rising edge, sampled 2 ns after it
    initial begin
        exp_t e;
        ins_t a0, a1;
        bit ok;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e  = q.pop_front();
                a0 = '{tag: is_tag[TAG_W-1:0], rd: is_rd[REG_W-1:0],
                       rs1: is_rs1[REG_W-1:0], rs2: is_rs2[REG_W-1:0]};
                a1 = '{tag: is_tag[2*TAG_W-1:TAG_W], rd: is_rd[2*REG_W-1:REG_W],
                       rs1: is_rs1[2*REG_W-1:REG_W], rs2: is_rs2[2*REG_W-1:REG_W]};
                ok = (is_vld == e.v) && (!e.v[0] || a0 == e.i0) && (!e.v[1] || a1 == e.i1);
                check(e.req, ok,
                      $sformatf("v=%b l0=%h l1=%h", is_vld, a0, a1),
                      $sformatf("v=%b l0=%h l1=%h", e.v, e.i0, e.i1));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        slot_t nil;
        slot_t s0, s1;
        bit    carry_before;
        int    idx;
        nil = '0;
        // reset, then R1 check on the ports
        step(nil, nil, 1);
        step(nil, nil, 1);
        // R2: clean pair
        step(sv(mk(1, 3, 1, 2)), sv(mk(2, 4, 5, 6)), 0);
        // R3: younger rs1 reads older rd
        step(sv(mk(3, 7, 1, 2)), sv(mk(4, 8, 7, 1)), 0);
        // R6: carried B pairs with new slot 0; slot 1 (tag 6) must be ignored
        step(sv(mk(5, 9, 1, 2)), sv(mk(6, 10, 2, 3)), 0);
        // R3 via rs2: tag 6 re-offered as slot 0
        step(sv(mk(6, 10, 2, 3)), sv(mk(7, 11, 3, 10)), 0);
        // R4 chained: carried rd11 against new rd11
        step(sv(mk(8, 11, 1, 1)), nil, 0);
        // R3 chained again: new reads r11
        step(sv(mk(9, 12, 11, 0)), nil, 0);
        // R7: carried instruction with invalid slot 0 issues alone
        step(nil, sv(mk(99, 1, 1, 1)), 0);
        // R5: register 0 everywhere, no conflict
        step(sv(mk(10, 0, 1, 2)), sv(mk(11, 0, 0, 0)), 0);
        // R7: older slot a bubble, younger moves to lane 0
        step(nil, sv(mk(12, 5, 1, 1)), 0);
        // R7: younger slot a bubble
        step(sv(mk(13, 6, 5, 5)), nil, 0);
        // R9: conflict, then reset drops the carried instruction
        step(sv(mk(14, 2, 1, 1)), sv(mk(15, 3, 2, 0)), 0);
        step(sv(mk(16, 4, 1, 1)), nil, 1);
        step(nil, nil, 0);
        step(nil, nil, 0);
        // random phase over a small register space to force many clashes
        for (int n = 0; n < 3000; n++) begin
            while (pend.size() < 2) begin
                pend.push_back(mk(int'(next_tag), int'($urandom % 4),
                                  int'($urandom % 4), int'($urandom % 4)));
                next_tag++;
            end
            idx = 0;
            s0 = nil; s1 = nil;
            if ($urandom % 6 != 0) begin s0 = sv(pend[0]); idx = 1; end
            if ($urandom % 6 != 0) s1 = sv(pend[idx]);
            carry_before = m_carry.v;
            step(s0, s1, 0);
            if (s0.v) void'(pend.pop_front());
            if (s1.v && !carry_before) void'(pend.pop_front());
        end
        step(nil, nil, 0);
        step(nil, nil, 0);
        @(posedge clk);
        #5;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule